// File: doc/BRIEF.md
# General-Purpose Bidirectional I/O Port

This block is an eight-pin general-purpose I/O port for a small microcontroller core. It is driven through a simple register bus with an address, write data, a write strobe and registered read data. Three registers sit on that bus:

- an output latch,
- a per-pin direction register,
- a drive-select bit that makes every output of the port either open-drain or push-pull.

Toward the pads the block produces registered output-value and output-enable vectors. It also models a weak bus keeper, which holds each undriven pin at the last level it had.

The pad is modelled with separate signals. `pad_in` carries the level that an outside source puts on a pin. `pad_ext` tells the block which pins such a source is actually driving. The level seen on a pin is resolved in a fixed order: the block's own drive first, then an outside driver, and otherwise the keeper. That resolved level is what the keeper tracks. It is also what a two-flop synchronizer passes to the read path.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset the direction register reads 0xFF (every pin an input), the drive-select bit reads 0, and the output latch is 0. `pad_oe`, `pad_out`, `pad_keep` and `bus_rdata` are all 0.
- R2: The direction register is at address 246 (0xF6). Bit i = 1 makes pin i an input and bit i = 0 makes it an output. An input pin never has its `pad_oe` bit set.
- R3: The drive-select bit is bit 0 of address 247 (0xF7). Bits 7..1 of that address always read 0, and writes to them are ignored.
- R4: With drive-select = 1 (push-pull), every output pin has `pad_oe` = 1 and `pad_out` equal to its latch bit.
- R5: With drive-select = 0 (open-drain), an output pin with latch bit 0 has `pad_oe` = 1 and `pad_out` = 0. An output pin with latch bit 1 has `pad_oe` = 0, which releases the pin. `pad_out` is 0 on every pin whose `pad_oe` is 0.
- R6: `pad_oe` and `pad_out` are registered. A register write captured at clock edge k shows on the pads at edge k+1.
- R7: The output latch is at address 2 and is written for all eight bits, including pins that are currently inputs. A latch bit written while its pin was an input is driven once the pin becomes an output.
- R8: Reading address 2 returns, bit by bit, the synchronized pin level for input pins and the latch value for output pins.
- R9: The resolved pin level passes through two flops before the read path. A level change that is present before edge 1 shows in `bus_rdata` after edge 3 and not after edge 2.
- R10: The resolved pin level is `pad_out` when `pad_oe` is set. Otherwise it is `pad_in` when the `pad_ext` bit is set. Otherwise it is the keeper value.
- R11: The keeper (`pad_keep`) takes the resolved pin level at every clock edge, so a pin that nothing drives holds its last level.
- R12: A read of any other address returns 0, and a write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| pad_in | input | 8 | Level put on each pin by an outside driver |
| pad_ext | input | 8 | Per pin, 1 when an outside driver is active |
| pad_out | output | 8 | Registered output value toward the pads |
| pad_oe | output | 8 | Registered output enable toward the pads |
| pad_keep | output | 8 | Level held by the keeper on each pin |

## Verification
A wrong direction or drive-select bit shows on `pad_oe` and `pad_out` one edge after the write that set it. A wrong keeper value shows on `pad_keep` at once. It also shows in the read data three edges later, because that value feeds the synchronizer whenever a pin is left floating. A synchronizer with the wrong depth moves the instant at which an input change appears on `bus_rdata`, so the bench samples exactly the second and third edges after such a change. A cycle-level reference model, together with the directed open-drain, keeper and latch-preload cases, compares every output at every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_CFG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 8,
  parameter int DATA_ADDR = 2,
  parameter int DIR_ADDR  = 246,
  parameter int CFG_ADDR  = 247
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          we_i,
  input  logic [W-1:0]  sync_i,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  latch_o,
  output logic          drive_o,
  output logic [W-1:0]  rdata_o
);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_ADDR);
  localparam logic [AW-1:0] A_DIR  = AW'(DIR_ADDR);
  localparam logic [AW-1:0] A_CFG  = AW'(CFG_ADDR);

  reg_sel_e       sel;
  logic [W-1:0]   dir_q, latch_q, rd_n, rdata_q;
  logic           drive_q;

  always_comb begin
    if (addr_i == A_DATA)     sel = SEL_DATA;
    else if (addr_i == A_DIR) sel = SEL_DIR;
    else if (addr_i == A_CFG) sel = SEL_CFG;
    else                      sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      latch_q <= '0;
      drive_q <= 1'b0;
    end else if (we_i) begin
      case (sel)
        SEL_DATA: latch_q <= wdata_i;
        SEL_DIR:  dir_q   <= wdata_i;
        SEL_CFG:  drive_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: rd_n = (dir_q & sync_i) | (~dir_q & latch_q);
      SEL_DIR:  rd_n = dir_q;
      SEL_CFG:  rd_n = {{(W-1){1'b0}}, drive_q};
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_n;
  end

  assign dir_o   = dir_q;
  assign latch_o = latch_q;
  assign drive_o = drive_q;
  assign rdata_o = rdata_q;

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == A_DIR) |=> (dir_o == $past(wdata_i)));

  assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i) == A_CFG) |-> (rdata_o[W-1:1] == '0));

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i) != A_DATA && $past(addr_i) != A_DIR && $past(addr_i) != A_CFG)
      |-> (rdata_o == '0));

  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i != A_DATA && addr_i != A_DIR && addr_i != A_CFG)
      |=> ($stable(dir_o) && $stable(latch_o) && $stable(drive_o)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] latch_i,
  input  logic         drive_i,
  input  logic [W-1:0] pad_in_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_keep_o,
  output logic [W-1:0] level_o
);
  for (genvar b = 0; b < W; b++) begin : g_pin
    logic oe_n, out_n, oe_q, out_q, keep_q, lvl;

    always_comb begin
      if (dir_i[b]) begin
        oe_n  = 1'b0;
        out_n = 1'b0;
      end else if (drive_i) begin
        oe_n  = 1'b1;
        out_n = latch_i[b];
      end else begin
        oe_n  = ~latch_i[b];
        out_n = 1'b0;
      end
    end

    always_comb begin
      if (oe_q)          lvl = out_q;
      else if (ext_i[b]) lvl = pad_in_i[b];
      else               lvl = keep_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        oe_q   <= 1'b0;
        out_q  <= 1'b0;
        keep_q <= 1'b0;
      end else begin
        oe_q   <= oe_n;
        out_q  <= out_n;
        keep_q <= lvl;
      end
    end

    assign pad_oe_o[b]   = oe_q;
    assign pad_out_o[b]  = out_q;
    assign pad_keep_o[b] = keep_q;
    assign level_o[b]    = lvl;
  end

  assert_input_released_R2: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe_o & $past(dir_i)) == '0));

  assert_od_low_only_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(drive_i)) |-> (pad_out_o == '0));

  assert_pp_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $past(drive_i) |-> (pad_oe_o == ~$past(dir_i)));

  assert_keeper_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (((pad_keep_o ^ $past(pad_keep_o)) & $past(~pad_oe_o & ~ext_i)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W         = 8,
  parameter int AW        = 8,
  parameter int DATA_ADDR = 2,
  parameter int DIR_ADDR  = 246,
  parameter int CFG_ADDR  = 247,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  input  logic [W-1:0]  pad_ext,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_keep
);
  logic [W-1:0] dir_w, latch_w, level_w, sync_w;
  logic         drive_w;

  gpio_regs #(
    .W(W), .AW(AW), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wdata_i(bus_wdata), .we_i(bus_we),
    .sync_i(sync_w), .dir_o(dir_w), .latch_o(latch_w), .drive_o(drive_w),
    .rdata_o(bus_rdata)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .clk(clk), .rst(rst), .dir_i(dir_w), .latch_i(latch_w), .drive_i(drive_w),
    .pad_in_i(pad_in), .ext_i(pad_ext), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_keep_o(pad_keep), .level_o(level_w)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d_i(level_w), .q_o(sync_w)
  );
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  localparam int W = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_DATA = 8'd2, A_DIR = 8'd246, A_CFG = 8'd247;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0, pin_in = '0, pin_ext = '0;
  logic          we = 1'b0;
  logic [W-1:0]  rdata, p_out, p_oe, p_keep;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  gpio_port dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .pad_in(pin_in), .pad_ext(pin_ext), .pad_out(p_out),
    .pad_oe(p_oe), .pad_keep(p_keep)
  );

  // reference model state, from the requirements
  logic [W-1:0] m_dir = '1, m_data = '0, m_oe = '0, m_out = '0, m_keep = '0;
  logic [W-1:0] m_s1 = '0, m_s2 = '0, m_rd = '0;
  logic         m_drive = 1'b0;

  function automatic logic [W-1:0] f_oe(logic [W-1:0] d, logic drv, logic [W-1:0] lat);
    return drv ? ~d : (~d & ~lat);
  endfunction

  function automatic logic [W-1:0] f_out(logic [W-1:0] d, logic drv, logic [W-1:0] lat);
    return drv ? (~d & lat) : '0;
  endfunction

  function automatic logic [W-1:0] f_level(logic [W-1:0] oe, logic [W-1:0] o,
                                           logic [W-1:0] ex, logic [W-1:0] pi,
                                           logic [W-1:0] kp);
    return (oe & o) | (~oe & ex & pi) | (~oe & ~ex & kp);
  endfunction

  function automatic logic [W-1:0] f_read(logic [AW-1:0] a, logic [W-1:0] d,
                                          logic [W-1:0] lat, logic drv,
                                          logic [W-1:0] s);
    if (a == A_DATA) return (d & s) | (~d & lat);
    if (a == A_DIR)  return d;
    if (a == A_CFG)  return {7'd0, drv};
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dir <= '1; m_data <= '0; m_drive <= 1'b0; m_oe <= '0; m_out <= '0;
      m_keep <= '0; m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
    end else begin
      m_keep <= f_level(m_oe, m_out, pin_ext, pin_in, m_keep);
      m_s1   <= f_level(m_oe, m_out, pin_ext, pin_in, m_keep);
      m_s2   <= m_s1;
      m_rd   <= f_read(addr, m_dir, m_data, m_drive, m_s2);
      m_oe   <= f_oe(m_dir, m_drive, m_data);
      m_out  <= f_out(m_dir, m_drive, m_data);
      if (we) begin
        if (addr == A_DATA) m_data <= wdata;
        else if (addr == A_DIR) m_dir <= wdata;
        else if (addr == A_CFG) m_drive <= wdata[0];
      end
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk("R2/R4/R5 pad_oe model", p_oe, m_oe);
      chk("R4/R5/R6 pad_out model", p_out, m_out);
      chk("R10/R11 pad_keep model", p_keep, m_keep);
      chk("R8/R9/R12 bus_rdata model", rdata, m_rd);
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk); addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    // R1 reset state
    chk("R1 pad_oe", p_oe, 8'h00);
    chk("R1 pad_out", p_out, 8'h00);
    chk("R1 pad_keep", p_keep, 8'h00);
    chk("R1 bus_rdata", rdata, 8'h00);
    rd(A_DIR, 8'hFF, "R1 direction");
    rd(A_CFG, 8'h00, "R1 drive select");

    // R9 synchronizer latency
    @(negedge clk); pin_ext = 8'hFF; pin_in = 8'hA5; addr = A_DATA;
    @(negedge clk);
    @(negedge clk); chk("R9 not after edge 2", rdata, 8'h00);
    @(negedge clk); chk("R9 after edge 3", rdata, 8'hA5);

    // R11 keeper holds after the outside driver lets go
    @(negedge clk); pin_ext = 8'h00;
    repeat (4) @(negedge clk);
    chk("R11 keeper", p_keep, 8'hA5);
    chk("R11 keeper read", rdata, 8'hA5);

    // R5 open drain
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h0F);
    @(negedge clk);
    chk("R5 od oe", p_oe, 8'hF0);
    chk("R5 od out", p_out, 8'h00);
    repeat (2) @(negedge clk);
    chk("R11 released od pin holds low", p_keep, 8'h00);
    rd(A_DATA, 8'h0F, "R8 output bits read latch");

    // R3, R4 push-pull
    wr(A_CFG, 8'hFF);
    rd(A_CFG, 8'h01, "R3 upper bits zero");
    chk("R4 pp oe", p_oe, 8'hFF);
    chk("R4 pp out", p_out, 8'h0F);

    // R7 latch preload on input pins
    wr(A_DIR, 8'hF0);
    wr(A_DATA, 8'hA3);
    repeat (4) @(negedge clk);
    chk("R2 inputs released", p_oe, 8'h0F);
    rd(A_DATA, 8'h03, "R8 mixed read");
    wr(A_DIR, 8'h00);
    @(negedge clk);
    chk("R7 preloaded latch driven", p_out, 8'hA3);

    // R12 unmapped address
    wr(8'h05, 8'h77);
    rd(8'h05, 8'h00, "R12 unmapped read");
    rd(A_DIR, 8'h00, "R12 direction unchanged");
    rd(A_CFG, 8'h01, "R12 drive unchanged");

    // R6 pad update one edge after the write edge
    wr(A_DATA, 8'h5A);
    chk("R6 pads not yet updated", p_out, 8'hA3);
    @(negedge clk);
    chk("R6 pads updated", p_out, 8'h5A);

    // R10 level priority: outside driver over keeper
    wr(A_DIR, 8'hFF);
    @(negedge clk); pin_ext = 8'h0F; pin_in = 8'h06; addr = A_DATA;
    repeat (4) @(negedge clk);
    chk("R10 level read", rdata, 8'h56);
    chk("R10 keeper follows level", p_keep, 8'h56);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pin_in  = 8'($urandom);
      pin_ext = 8'($urandom);
      wdata   = 8'($urandom);
      we      = ($urandom % 3) == 0;
      case ($urandom % 5)
        0, 1: addr = A_DATA;
        2:    addr = A_DIR;
        3:    addr = A_CFG;
        default: addr = 8'($urandom);
      endcase
    end
    @(negedge clk); we = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule